// File: doc/BRIEF.md
# Power-Up Strap Latch for Shared Clock Pads

This block manages three pads that serve two purposes. While the supply is first ramping (power-on reset asserted), each pad is read as a configuration input. At the end of power-on reset, the block does two things:

- It freezes the pad levels into internal configuration bits.
- It samples a mode input that decides whether the pads are later turned into clock output drivers.

If the mode input was low at that moment, the pads stay ordinary live inputs. Downstream logic then sees them through a synchronizer, and the block never drives them.

If the mode input was high, downstream logic sees the frozen bits from then on. Each pad is then driven with its own internal clock source, nominally a third of the 100 MHz rate.

A separate power-down request stops each driven pad cleanly. Every pad is allowed one complete cycle before it is held low. The frozen configuration is never re-read by a power-down request; only a new power-on reset re-reads it.

The configuration bits drive the frequency-select and spread-spectrum logic. The output enables and data go to the pad ring.

Top module: `strap_latch_top`

## Requirements
- R1: While `rst` is high, `pad_oe`, `pad_out`, `cfg_fsel` and `cfg_spread_n` are all zero.
- R2: At the first rising clock edge with `rst` low, `pad_in` and `mode_in` are captured. If the captured mode is 1, the configuration outputs show the captured pad levels right after that edge. The mapping is pad bit 0 to `cfg_fsel[0]`, pad bit 1 to `cfg_fsel[1]`, and pad bit 2 to `cfg_spread_n` (active-low spread enable).
- R3: After capture in mode 1, changes on `pad_in` or `mode_in` do not change `cfg_fsel`, `cfg_spread_n` or `pad_oe` until the next power-on reset.
- R4: With mode 1 captured, `pad_oe` is all zero after the capture edge and all ones from the following edge onward.
- R5: With mode 0 captured, `pad_oe` and `pad_out` stay zero, even if `mode_in` is later raised.
- R6: With mode 0 captured, the configuration outputs equal `pad_in` as sampled two rising edges earlier (two-flop synchronizer).
- R7: While enabled and running, `pad_out[i]` after each edge equals `clk_src[i]` sampled at that edge.
- R8: Once `pwrdn_req` is seen high at an edge, each pad keeps copying its source until it has sampled, in order, a fall, a rise and a fall of that source. From then on the pad is held low for as long as the request stays high. A request released before that sequence completes returns the pad to normal copying.
- R9: After the request is released, a held pad restarts at the first edge at which its source samples low. It copies its source again from the next edge.
- R10: Asserting and releasing `pwrdn_req` leaves `cfg_fsel`, `cfg_spread_n` and `pad_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset; capture follows its release |
| pwrdn_req | input | 1 | Power-down request, active high, synchronous to `clk` |
| mode_in | input | 1 | Mode: 1 turns the pads into clock outputs after capture |
| pad_in | input | 3 | Levels read from the three shared pads |
| clk_src | input | 3 | Internal clock sources, one per pad |
| pad_oe | output | 3 | Per-pad output enable |
| pad_out | output | 3 | Per-pad output data |
| cfg_fsel | output | 2 | Frequency-select configuration bits |
| cfg_spread_n | output | 1 | Active-low spread-spectrum enable configuration bit |

## Verification
A corrupted capture register shows up on the configuration outputs on the first edge after reset release. A wrongly captured mode flips `pad_oe` one edge later. A missed hold shows up as soon as the pads are wiggled after capture. A fault in a pad's stop sequence changes `pad_out` within a few source periods of a power-down request or its release. The synchronizer depth shows up as a one-edge shift of the live configuration, which is visible on the first random pad change.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Number of shared pads; the configuration fields below depend on it.
    localparam int NPADS = 3;

    // Per-pad stop sequence used during a power-down request.
    typedef enum logic [2:0] {
        G_RUN     = 3'd0,
        G_WAIT_F1 = 3'd1,
        G_WAIT_R  = 3'd2,
        G_WAIT_F2 = 3'd3,
        G_HALT    = 3'd4
    } gate_e;

    // Configuration seen by downstream logic.
    typedef struct packed {
        logic       spread_n;
        logic [1:0] fsel;
    } strap_cfg_t;

    function automatic strap_cfg_t unpack_pads(input logic [NPADS-1:0] p);
        strap_cfg_t r;
        r.fsel     = p[1:0];
        r.spread_n = p[2];
        return r;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_in,
    input  logic [NPADS-1:0] pad_in,
    output logic             cap_done,
    output logic             mode_q,
    output logic [NPADS-1:0] strap_q,
    output logic             arm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_done <= 1'b0;
            mode_q   <= 1'b0;
            strap_q  <= '0;
            arm_q    <= 1'b0;
        end else begin
            // Output enable follows capture by one edge.
            arm_q <= cap_done & mode_q;
            if (!cap_done) begin
                cap_done <= 1'b1;
                mode_q   <= mode_in;
                strap_q  <= pad_in;
            end
        end
    end

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cap_done) && !$past(rst)) |-> ($stable(strap_q) && $stable(mode_q)));

    // R4
    arm_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(arm_q) && !$past(rst)) |-> ($past(cap_done) && mode_q));

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pad_gate.sv
module pad_gate
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_req,
    input  logic oe,
    input  logic src,
    output logic out_q
);

    gate_e g_q, g_d;
    logic  src_q;
    logic  fall, rise;

    assign fall = src_q & ~src;
    assign rise = ~src_q & src;

    always_comb begin
        g_d = g_q;
        unique case (g_q)
            G_RUN:     if (pwrdn_req) g_d = G_WAIT_F1;
            G_WAIT_F1: if (!pwrdn_req) g_d = G_RUN; else if (fall) g_d = G_WAIT_R;
            G_WAIT_R:  if (!pwrdn_req) g_d = G_RUN; else if (rise) g_d = G_WAIT_F2;
            G_WAIT_F2: if (!pwrdn_req) g_d = G_RUN; else if (fall) g_d = G_HALT;
            G_HALT:    if (!pwrdn_req && !src) g_d = G_RUN;
            default:   g_d = G_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q   <= G_RUN;
            src_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            g_q   <= g_d;
            src_q <= src;
            out_q <= oe & src & (g_q != G_HALT);
        end
    end

    // R8
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ((g_q == G_HALT) && ($past(g_q) != G_HALT) && !$past(rst)) |-> $past(pwrdn_req));

    // R9
    halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ((g_q == G_RUN) && ($past(g_q) == G_HALT) && !$past(rst)) |-> !$past(src));

endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwrdn_req,
    input  logic             mode_in,
    input  logic [NPADS-1:0] pad_in,
    input  logic [NPADS-1:0] clk_src,
    output logic [NPADS-1:0] pad_oe,
    output logic [NPADS-1:0] pad_out,
    output logic [1:0]       cfg_fsel,
    output logic             cfg_spread_n
);

    logic             cap_done, mode_q, arm_q;
    logic [NPADS-1:0] strap_q, live_q;
    strap_cfg_t       cfg;

    strap_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .pad_in   (pad_in),
        .cap_done (cap_done),
        .mode_q   (mode_q),
        .strap_q  (strap_q),
        .arm_q    (arm_q)
    );

    bit_sync #(.W(NPADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (live_q)
    );

    generate
        for (genvar i = 0; i < NPADS; i++) begin : g_pad
            pad_gate u_gate (
                .clk       (clk),
                .rst       (rst),
                .pwrdn_req (pwrdn_req),
                .oe        (arm_q),
                .src       (clk_src[i]),
                .out_q     (pad_out[i])
            );
        end
    endgenerate

    assign pad_oe       = {NPADS{arm_q}};
    assign cfg          = mode_q ? unpack_pads(strap_q) : unpack_pads(live_q);
    assign cfg_fsel     = cfg.fsel;
    assign cfg_spread_n = cfg.spread_n;

    // R5
    oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (|pad_oe) |-> (mode_q && cap_done));

    // R7
    out_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R6
    live_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !$past(rst) && !$past(rst, 2)) |-> ({cfg_spread_n, cfg_fsel} == $past(pad_in, 2)));

endmodule

// File: tb/sim_strap_latch_top.sv
module sim_strap_latch_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrdn_req = 1'b0;
    logic       mode_in = 1'b0;
    logic [2:0] pad_in = 3'b000;
    logic [2:0] clk_src = 3'b000;
    logic [2:0] pad_oe, pad_out;
    logic [1:0] cfg_fsel;
    logic       cfg_spread_n;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit       m_cap, m_mode, m_arm;
    bit [2:0] m_strap, m_s1, m_s2, m_out, m_sp;
    int       m_g [3];

    // source generator
    int cnt = 0;
    int halfp [3] = '{2, 3, 4};
    int phase [3] = '{0, 1, 2};

    always #5 clk = ~clk;

    strap_latch_top u0 (
        .clk          (clk),
        .rst          (rst),
        .pwrdn_req    (pwrdn_req),
        .mode_in      (mode_in),
        .pad_in       (pad_in),
        .clk_src      (clk_src),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .cfg_fsel     (cfg_fsel),
        .cfg_spread_n (cfg_spread_n)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [2:0] exp_cfg();
        return m_mode ? m_strap : m_s2;
    endfunction

    // model of one rising edge, from the requirements
    task automatic model_edge();
        bit       old_arm;
        bit       fall, rise;
        old_arm = m_arm;
        if (rst) begin
            m_cap = 0; m_mode = 0; m_arm = 0; m_strap = 0;
            m_s1 = 0; m_s2 = 0; m_out = 0; m_sp = 0;
            for (int i = 0; i < 3; i++) m_g[i] = 0;
        end else begin
            m_arm = m_cap & m_mode;
            if (!m_cap) begin
                m_cap = 1; m_mode = mode_in; m_strap = pad_in;
            end
            m_s2 = m_s1; m_s1 = pad_in;
            for (int i = 0; i < 3; i++) begin
                m_out[i] = old_arm & clk_src[i] & (m_g[i] != 4);
                fall = m_sp[i] & ~clk_src[i];
                rise = ~m_sp[i] & clk_src[i];
                case (m_g[i])
                    0: if (pwrdn_req) m_g[i] = 1;
                    1: if (!pwrdn_req) m_g[i] = 0; else if (fall) m_g[i] = 2;
                    2: if (!pwrdn_req) m_g[i] = 0; else if (rise) m_g[i] = 3;
                    3: if (!pwrdn_req) m_g[i] = 0; else if (fall) m_g[i] = 4;
                    default: if (!pwrdn_req && !clk_src[i]) m_g[i] = 0;
                endcase
                m_sp[i] = clk_src[i];
            end
        end
    endtask

    // one cycle: inputs already driven at negedge; compare at next negedge
    task automatic step(input string rc, input string ro, input string rp);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(rc, {cfg_spread_n, cfg_fsel}, exp_cfg());
        check(ro, pad_oe, {3{m_arm}});
        check(rp, pad_out, m_out);
        cnt++;
        for (int i = 0; i < 3; i++) clk_src[i] = ((cnt + phase[i]) / halfp[i]) % 2;
    endtask

    task automatic power_up(input bit mode, input logic [2:0] pads, input int hold);
        rst = 1'b1;
        mode_in = mode;
        pad_in = pads;
        for (int k = 0; k < hold; k++) step("R1", "R1", "R1");
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1: reset state, with mode and pads active
        power_up(1'b1, 3'b111, 4);

        // Mode 0 capture: live synchronized path, no drive (R5, R6)
        rst = 1'b1;
        mode_in = 1'b0;
        pad_in = 3'b110;
        step("R1", "R1", "R1");
        rst = 1'b0;
        for (int k = 0; k < 40; k++) begin
            step("R6", "R5", "R5");
            pad_in  = 3'($urandom);
            mode_in = (k > 3) ? 1'($urandom) : 1'b0;
        end
        pwrdn_req = 1'b1;
        for (int k = 0; k < 6; k++) step("R6", "R5", "R5");
        pwrdn_req = 1'b0;

        // Mode 1 capture, directed value 101 (R2, R4)
        power_up(1'b1, 3'b101, 3);
        step("R2", "R4", "R7");
        check("R2", {cfg_spread_n, cfg_fsel}, 3'b101);
        check("R4", pad_oe, 3'b000);
        pad_in = 3'b010;
        mode_in = 1'b0;
        step("R3", "R4", "R7");
        check("R4", pad_oe, 3'b111);

        // hold against random pad and mode activity, clock copying (R3, R7)
        for (int k = 0; k < 60; k++) begin
            pad_in  = 3'($urandom);
            mode_in = 1'($urandom);
            step("R3", "R3", "R7");
        end
        check("R3", {cfg_spread_n, cfg_fsel}, 3'b101);

        // power-down sequences (R8, R9, R10)
        for (int rep = 0; rep < 4; rep++) begin
            pwrdn_req = 1'b1;
            for (int k = 0; k < 3 + (rep == 1 ? 0 : 20 + int'($urandom % 8)); k++) begin
                pad_in = 3'($urandom);
                step("R10", "R10", "R8");
            end
            if (rep != 1) check("R8", pad_out, 3'b000);
            pwrdn_req = 1'b0;
            for (int k = 0; k < 15 + int'($urandom % 6); k++) step("R10", "R10", "R9");
        end
        check("R10", {cfg_spread_n, cfg_fsel}, 3'b101);
        check("R10", pad_oe, 3'b111);

        // second supply application with another directed value (R2)
        phase = '{3, 0, 1};
        power_up(1'b1, 3'b010, 2);
        step("R2", "R4", "R7");
        check("R2", {cfg_spread_n, cfg_fsel}, 3'b010);
        for (int k = 0; k < 30; k++) begin
            pad_in = 3'($urandom);
            step("R3", "R4", "R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule